// File: doc/BRIEF.md
# Skewed Two-Stage Pipelined Adder

This block adds two 4-bit operands with a carry-in. The add is split into two ripple slices of two bits each, and a register sits between them. The low slice adds operand bits [1:0] and the carry-in. Its two sum bits and its carry-out are registered. On the next cycle the high slice adds operand bits [3:2] together with that registered carry. It then registers sum bits [3:2] and the final carry-out.

The ports are skewed on purpose, so the block can start a new addition on every clock. The low operand bits arrive with a valid strobe. The matching high operand bits must arrive one cycle later. Results leave with the same skew: the low sum bits come out one cycle before the high sum bits and the carry-out. A valid flag moves with each slice, so the neighbouring logic can tell a live result from a held one. The neighbours on both sides are expected to handle the skew themselves; the block adds no deskew registers.

Top module: `skew_add`

## Requirements
- R1: While rst_ni is low, valid_lo_o, valid_hi_o, sum_lo_o, sum_hi_o and carry_o are all 0.
- R2: When valid_i is 1 at a rising edge, valid_lo_o is 1 after that edge. sum_lo_o then equals bits [1:0] of a_lo_i + b_lo_i + carry_i, sampled at that edge.
- R3: The high operand bits (a_hi_i, b_hi_i) are sampled at the edge one cycle after their low bits. After that edge, sum_hi_o equals bits [3:2] of the full 4-bit sum A + B + carry_i, with A = {a_hi_i, a_lo_i} and B = {b_hi_i, b_lo_i}.
- R4: carry_o is bit 4 of that full sum. It updates at the same edge as sum_hi_o.
- R5: Additions may be issued on every consecutive cycle, with no bubbles, and each result is still correct.
- R6: valid_hi_o equals the value valid_lo_o had one cycle earlier.
- R7: At an edge where valid_i is 0, sum_lo_o keeps its value and the low operands and carry_i are ignored. At an edge where valid_lo_o is 0, sum_hi_o and carry_o keep their values and the high operands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Low operand slice is valid this cycle |
| a_lo_i | input | 2 | Operand A bits [1:0] |
| b_lo_i | input | 2 | Operand B bits [1:0] |
| carry_i | input | 1 | Carry-in, arrives with the low slice |
| a_hi_i | input | 2 | Operand A bits [3:2], one cycle after the low slice |
| b_hi_i | input | 2 | Operand B bits [3:2], one cycle after the low slice |
| valid_lo_o | output | 1 | sum_lo_o holds a new result |
| sum_lo_o | output | 2 | Sum bits [1:0] |
| valid_hi_o | output | 1 | sum_hi_o and carry_o hold a new result |
| sum_hi_o | output | 2 | Sum bits [3:2] |
| carry_o | output | 1 | Final carry-out (sum bit 4) |

## Verification
The low sum is due one rising edge after its operands are presented. The high sum and the carry-out are due one edge after the high operands, which is two edges after the low operands. The bench drives each cycle's inputs on the falling edge and checks both slices on the next falling edge. In each such window it pairs the low result of addition k with the high result of addition k-1. In cycles without a valid flag it compares the outputs with the last values it expects to be held.

// File: rtl/skew_add_pkg.sv
package skew_add_pkg;
  parameter int unsigned DEF_SLICE_W = 2;
  localparam int unsigned N_SLICES = 2;
endpackage

// File: rtl/skew_add_ripple.sv
module skew_add_ripple #(
  parameter int unsigned SLICE_W = skew_add_pkg::DEF_SLICE_W
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               c_o
);
  logic [SLICE_W:0] chain;

  assign chain[0] = c_i;

  for (genvar g = 0; g < SLICE_W; g++) begin : g_fa
    assign sum_o[g]     = a_i[g] ^ b_i[g] ^ chain[g];
    assign chain[g + 1] = (a_i[g] & b_i[g]) | (chain[g] & (a_i[g] ^ b_i[g]));
  end

  assign c_o = chain[SLICE_W];
endmodule

// File: rtl/skew_add_stage.sv
module skew_add_stage #(
  parameter int unsigned SLICE_W = skew_add_pkg::DEF_SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               c_i,
  output logic               valid_o,
  output logic [SLICE_W-1:0] sum_o,
  output logic               c_o
);
  logic [SLICE_W-1:0] sum_d;
  logic               c_d;

  skew_add_ripple #(.SLICE_W(SLICE_W)) u_ripple (
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (c_i),
    .sum_o(sum_d),
    .c_o  (c_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      c_o     <= 1'b0;
    end else begin
      valid_o <= en_i;
      // hold result when slice is idle
      if (en_i) begin
        sum_o <= sum_d;
        c_o   <= c_d;
      end
    end
  end
endmodule

// File: rtl/skew_add.sv
module skew_add #(
  parameter int unsigned SLICE_W = skew_add_pkg::DEF_SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [SLICE_W-1:0] a_lo_i,
  input  logic [SLICE_W-1:0] b_lo_i,
  input  logic               carry_i,
  input  logic [SLICE_W-1:0] a_hi_i,
  input  logic [SLICE_W-1:0] b_hi_i,
  output logic               valid_lo_o,
  output logic [SLICE_W-1:0] sum_lo_o,
  output logic               valid_hi_o,
  output logic [SLICE_W-1:0] sum_hi_o,
  output logic               carry_o
);
  logic mid_carry_q;  // inter-stage carry register

  skew_add_stage #(.SLICE_W(SLICE_W)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .a_i    (a_lo_i),
    .b_i    (b_lo_i),
    .c_i    (carry_i),
    .valid_o(valid_lo_o),
    .sum_o  (sum_lo_o),
    .c_o    (mid_carry_q)
  );

  skew_add_stage #(.SLICE_W(SLICE_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_lo_o),
    .a_i    (a_hi_i),
    .b_i    (b_hi_i),
    .c_i    (mid_carry_q),
    .valid_o(valid_hi_o),
    .sum_o  (sum_hi_o),
    .c_o    (carry_o)
  );
endmodule

// File: rtl/skew_add_chk.sv
module skew_add_chk #(
  parameter int unsigned SLICE_W = skew_add_pkg::DEF_SLICE_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [SLICE_W-1:0] a_lo_i,
  input logic [SLICE_W-1:0] b_lo_i,
  input logic               carry_i,
  input logic [SLICE_W-1:0] a_hi_i,
  input logic [SLICE_W-1:0] b_hi_i,
  input logic               valid_lo_o,
  input logic [SLICE_W-1:0] sum_lo_o,
  input logic               valid_hi_o,
  input logic [SLICE_W-1:0] sum_hi_o,
  input logic               carry_o
);
  localparam int unsigned W = 2 * SLICE_W;

  always_comb begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!valid_lo_o && !valid_hi_o && sum_lo_o == '0 &&
                                sum_hi_o == '0 && !carry_o);
    end
  end

  p_lo_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_lo_o);

  p_lo_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sum_lo_o == SLICE_W'({1'b0, $past(a_lo_i)} + {1'b0, $past(b_lo_i)} +
                                     (SLICE_W + 1)'($past(carry_i))));

  // R3, R4, R5: full result assembled across the skew
  p_full_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_lo_o |=> {carry_o, sum_hi_o, $past(sum_lo_o)} ==
                   ({1'b0, $past(a_hi_i), $past(a_lo_i, 2)} +
                    {1'b0, $past(b_hi_i), $past(b_lo_i, 2)} +
                    (W + 1)'($past(carry_i, 2))));

  p_hi_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_lo_o |=> valid_hi_o);

  p_hi_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_lo_o |=> !valid_hi_o);

  p_lo_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_lo_o));

  p_hi_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_lo_o |=> ($stable(sum_hi_o) && $stable(carry_o)));
endmodule

bind skew_add skew_add_chk #(.SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/skew_add_tb.sv
module skew_add_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2;
  localparam int W = 2 * SW;
  localparam int MAX_OPS = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [SW-1:0] a_lo_i = '0, b_lo_i = '0, a_hi_i = '0, b_hi_i = '0;
  logic          carry_i = 1'b0;
  logic          valid_lo_o, valid_hi_o, carry_o;
  logic [SW-1:0] sum_lo_o, sum_hi_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [W-1:0] op_a[MAX_OPS];
  logic [W-1:0] op_b[MAX_OPS];
  bit           op_c[MAX_OPS];
  bit           op_v[MAX_OPS];

  logic [SW-1:0] exp_lo = '0, exp_hi = '0;
  logic          exp_co = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  skew_add #(.SLICE_W(SW)) dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives op i low slice and op i-1 high slice each cycle; checks both on the next falling edge.
  task automatic run_seq(input int n);
    for (int i = 0; i <= n; i++) begin
      logic [W:0] full;
      valid_i = (i < n) ? op_v[i] : 1'b0;
      a_lo_i  = (i < n) ? op_a[i][SW-1:0] : SW'($urandom);
      b_lo_i  = (i < n) ? op_b[i][SW-1:0] : SW'($urandom);
      carry_i = (i < n) ? op_c[i] : 1'($urandom);
      if (i > 0) begin
        a_hi_i = op_a[i-1][W-1:SW];
        b_hi_i = op_b[i-1][W-1:SW];
      end else begin
        a_hi_i = SW'($urandom);
        b_hi_i = SW'($urandom);
      end
      @(posedge clk_i);
      @(negedge clk_i);
      if (i < n && op_v[i]) begin
        full = {1'b0, op_a[i]} + {1'b0, op_b[i]} + (W + 1)'(op_c[i]);
        exp_lo = full[SW-1:0];
        chk("R2", "valid_lo_o", int'(valid_lo_o), 1);
      end else begin
        chk("R7", "valid_lo_o idle", int'(valid_lo_o), 0);
      end
      chk("R2", "sum_lo_o", int'(sum_lo_o), int'(exp_lo));
      if (i > 0 && op_v[i-1]) begin
        full = {1'b0, op_a[i-1]} + {1'b0, op_b[i-1]} + (W + 1)'(op_c[i-1]);
        exp_hi = full[W-1:SW];
        exp_co = full[W];
        chk("R6", "valid_hi_o", int'(valid_hi_o), 1);
      end else begin
        chk("R6", "valid_hi_o idle", int'(valid_hi_o), 0);
      end
      chk("R3", "sum_hi_o", int'(sum_hi_o), int'(exp_hi));
      chk("R4", "carry_o", int'(carry_o), int'(exp_co));
    end
  endtask

  task automatic t_reset();
    #(CLK_PERIOD * 2);
    chk("R1", "valid_lo_o", int'(valid_lo_o), 0);
    chk("R1", "valid_hi_o", int'(valid_hi_o), 0);
    chk("R1", "sum_lo_o", int'(sum_lo_o), 0);
    chk("R1", "sum_hi_o", int'(sum_hi_o), 0);
    chk("R1", "carry_o", int'(carry_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // Corner operands, isolated by idle cycles (R2, R3, R4, R7)
  task automatic t_corner();
    logic [W-1:0] ca[6] = '{4'h0, 4'hF, 4'hF, 4'h3, 4'hC, 4'h5};
    logic [W-1:0] cb[6] = '{4'h0, 4'h0, 4'hF, 4'h1, 4'h4, 4'hA};
    bit           cc[6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    for (int k = 0; k < 6; k++) begin
      op_a[2*k] = ca[k]; op_b[2*k] = cb[k]; op_c[2*k] = cc[k]; op_v[2*k] = 1'b1;
      op_a[2*k+1] = W'($urandom); op_b[2*k+1] = W'($urandom);
      op_c[2*k+1] = 1'($urandom); op_v[2*k+1] = 1'b0;
    end
    run_seq(12);
  endtask

  // Back-to-back random stream (R5)
  task automatic t_stream();
    for (int k = 0; k < 40; k++) begin
      op_a[k] = W'($urandom); op_b[k] = W'($urandom);
      op_c[k] = 1'($urandom); op_v[k] = 1'b1;
    end
    run_seq(40);
  endtask

  // Random bubbles; idle operands must not disturb outputs (R7)
  task automatic t_bubbles();
    for (int k = 0; k < MAX_OPS; k++) begin
      op_a[k] = W'($urandom); op_b[k] = W'($urandom);
      op_c[k] = 1'($urandom); op_v[k] = ($urandom % 3) != 0;
    end
    run_seq(MAX_OPS);
  endtask

  initial begin
    t_reset();
    t_corner();
    t_stream();
    t_bubbles();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule